// File: doc/BRIEF.md
# Mirrored Video Memory with Blanking-Time Copy

This block holds two identical copies of video memory and keeps the renderer and the CPU apart. The renderer only ever reads the render copy. The CPU only ever writes the CPU copy. Neither side waits on the other during active display. When blanking begins, a copy engine moves the whole CPU copy into the render copy. The next frame then shows everything the CPU wrote, and the CPU copy still holds all of its own changes.

Each copy is split into `NSEG` segments. Every segment is a dual-port RAM with its own controls. During a copy, all segments work in parallel and both ports of every RAM are busy. Port 0 moves the even offsets and port 1 moves the odd offsets, so a segment of depth D is done in D/2 read cycles plus one write cycle.

While the copy runs, the CPU is stalled through a valid/ready handshake and renderer reads are refused. If display starts before the copy has finished, the frame is flagged as dropped. The renderer then replays its previous image instead of reading the memory that is being overwritten.

Top module: `vram_mirror_sync`

## Requirements
- R1: After reset, `sync_busy`, `sync_done`, `rd_valid` and `frame_dropped` are low and `cpu_ready` is high.
- R2: A word address splits into a segment index in its upper `log2(NSEG)` bits and an offset in its lower `SEG_AW` bits (with the defaults, bits 5:4 and 3:0). A renderer read with `rd_en` high returns the render-copy word at `rd_addr` on `rd_data`, with `rd_valid` high, one cycle later. `rd_valid` is low after a cycle without `rd_en`.
- R3: CPU writes change only the CPU copy. The render copy keeps its previous contents until a copy is run.
- R4: A `blank_start` pulse while idle starts a copy. `sync_busy` is then high for exactly 2^(SEG_AW-1)+1 cycles (9 with the defaults). During that time `cpu_ready` is low and a renderer read returns `rd_valid` low.
- R5: `sync_done` is a single-cycle pulse in the first cycle after `sync_busy` falls.
- R6: After a copy, every address of the render copy equals the CPU copy. The CPU copy is left unchanged, so addresses the CPU does not rewrite keep their value through later copies.
- R7: A CPU write accepted on the same clock edge that starts a copy is included in that copy.
- R8: A `display_start` pulse while a copy is running sets `frame_dropped`. A `display_start` pulse while idle clears it. Otherwise the flag holds its value.
- R9: A `blank_start` pulse while a copy is running is ignored and does not lengthen it.
- R10: A CPU write held valid while stalled is performed once `cpu_ready` returns, and it appears in the render copy after the next copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| blank_start | input | 1 | Pulse at the start of blanking; starts a copy |
| display_start | input | 1 | Pulse at the start of active display |
| cpu_valid | input | 1 | CPU write request |
| cpu_ready | output | 1 | Write accepted on this edge when high together with `cpu_valid` |
| cpu_addr | input | AW | CPU write word address |
| cpu_data | input | DW | CPU write data |
| rd_en | input | 1 | Renderer read request |
| rd_addr | input | AW | Renderer read word address |
| rd_valid | output | 1 | `rd_data` holds the result of last cycle's read |
| rd_data | output | DW | Renderer read data |
| sync_busy | output | 1 | Copy in progress |
| sync_done | output | 1 | One-cycle pulse when a copy completes |
| frame_dropped | output | 1 | The current frame started before the copy had finished |

## Verification
The hardest case to reach is a frame that starts while a copy is still running, combined with a repeated blanking pulse that must not restart the copy. The bench starts a copy and then walks it cycle by cycle. It injects `display_start` on the third cycle and a second `blank_start` on the fourth. It counts the busy cycles and locates the done pulse. It then reads back every address to show that the overlapping pulses did not corrupt the copy. Full reads of the render copy before and after each copy, over differing patterns and a sparse rewrite, show both the isolation and the write-through.

// File: rtl/vram_sync_pkg.sv
package vram_sync_pkg;
    localparam int NUM_COPIES  = 2;
    localparam int RENDER_COPY = 0;
    localparam int CPU_COPY    = 1;
    localparam int NUM_PORTS   = 2;
endpackage

// File: rtl/vram_bank.sv
module vram_bank #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic                clk,
    input  logic [1:0]          we,
    input  logic [1:0][AW-1:0]  addr,
    input  logic [1:0][DW-1:0]  wdata,
    output logic [1:0][DW-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int p = 0; p < 2; p++) begin
            if (we[p]) mem[addr[p]] <= wdata[p];
            rdata[p] <= mem[addr[p]];
        end
    end
endmodule

// File: rtl/vram_copy_ctrl.sv
module vram_copy_ctrl #(
    parameter int SEG_AW = 4,
    parameter int SEG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blank_start,
    input  logic              display_start,
    input  logic              rd_en,
    input  logic [SEG_W-1:0]  rd_seg_in,
    output logic              busy,
    output logic [SEG_AW-2:0] rd_cnt,
    output logic              wr_v,
    output logic [SEG_AW-2:0] wr_k,
    output logic              done,
    output logic              dropped,
    output logic              rd_valid,
    output logic [SEG_W-1:0]  rd_seg
);
    localparam int HW   = SEG_AW - 1;
    localparam int HALF = 1 << HW;
    localparam logic [HW-1:0] LAST = HW'(HALF - 1);

    typedef struct packed {
        logic             busy;
        logic             rd_act;
        logic [HW-1:0]    rd_cnt;
        logic             wr_v;
        logic [HW-1:0]    wr_k;
        logic             done;
        logic             dropped;
        logic             rd_valid;
        logic [SEG_W-1:0] rd_seg;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.done     = 1'b0;
        st_d.rd_valid = rd_en && !st_q.busy;
        st_d.rd_seg   = rd_seg_in;
        if (display_start) st_d.dropped = st_q.busy;
        if (!st_q.busy) begin
            if (blank_start) begin
                st_d.busy   = 1'b1;
                st_d.rd_act = 1'b1;
                st_d.rd_cnt = '0;
                st_d.wr_v   = 1'b0;
            end
        end else begin
            st_d.wr_v = st_q.rd_act;
            st_d.wr_k = st_q.rd_cnt;
            if (st_q.rd_act) begin
                if (st_q.rd_cnt == LAST) st_d.rd_act = 1'b0;
                else                     st_d.rd_cnt = st_q.rd_cnt + 1'b1;
            end
            if (st_q.wr_v && st_q.wr_k == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.wr_v = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign rd_cnt   = st_q.rd_cnt;
    assign wr_v     = st_q.wr_v;
    assign wr_k     = st_q.wr_k;
    assign done     = st_q.done;
    assign dropped  = st_q.dropped;
    assign rd_valid = st_q.rd_valid;
    assign rd_seg   = st_q.rd_seg;

    // R5: done follows directly on the end of a busy period
    p_done_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (!st_q.busy && $past(st_q.busy)));

    // R4: renderer gets no data in the cycle after a busy cycle
    p_rd_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> !st_q.rd_valid);

    // R4: every copy begins at offset pair zero with reading active
    p_copy_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> (st_q.rd_act && st_q.rd_cnt == '0));

    // R8: a dropped frame only ever follows a running copy
    p_drop_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.dropped) |-> $past(st_q.busy));

    // R6: writes into the render copy happen only inside a copy
    p_write_in_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_v |-> st_q.busy);
endmodule

// File: rtl/vram_mirror_sync.sv
module vram_mirror_sync
    import vram_sync_pkg::*;
#(
    parameter int DW     = 8,
    parameter int NSEG   = 4,
    parameter int SEG_AW = 4,
    localparam int SEG_W = (NSEG > 1) ? $clog2(NSEG) : 1,
    localparam int AW    = SEG_W + SEG_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blank_start,
    input  logic          display_start,
    input  logic          cpu_valid,
    output logic          cpu_ready,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          sync_busy,
    output logic          sync_done,
    output logic          frame_dropped
);
    logic                  busy, wr_v;
    logic [SEG_AW-2:0]     rd_cnt, wr_k;
    logic [SEG_W-1:0]      rd_seg_q;

    logic [SEG_W-1:0]  cpu_seg, rd_seg;
    logic [SEG_AW-1:0] cpu_off, rd_off;
    assign cpu_seg = cpu_addr[AW-1:SEG_AW];
    assign cpu_off = cpu_addr[SEG_AW-1:0];
    assign rd_seg  = rd_addr[AW-1:SEG_AW];
    assign rd_off  = rd_addr[SEG_AW-1:0];

    logic [NUM_PORTS-1:0]             bk_we   [NUM_COPIES][NSEG];
    logic [NUM_PORTS-1:0][SEG_AW-1:0] bk_addr [NUM_COPIES][NSEG];
    logic [NUM_PORTS-1:0][DW-1:0]     bk_wd   [NUM_COPIES][NSEG];
    logic [NUM_PORTS-1:0][DW-1:0]     bk_rd   [NUM_COPIES][NSEG];

    vram_copy_ctrl #(.SEG_AW(SEG_AW), .SEG_W(SEG_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .blank_start  (blank_start),
        .display_start(display_start),
        .rd_en        (rd_en),
        .rd_seg_in    (rd_seg),
        .busy         (busy),
        .rd_cnt       (rd_cnt),
        .wr_v         (wr_v),
        .wr_k         (wr_k),
        .done         (sync_done),
        .dropped      (frame_dropped),
        .rd_valid     (rd_valid),
        .rd_seg       (rd_seg_q)
    );

    always_comb begin
        for (int s = 0; s < NSEG; s++) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                bk_addr[CPU_COPY][s][p] = busy ? {rd_cnt, 1'(p)}
                                        : ((p == 0) ? cpu_off : '0);
                bk_we[CPU_COPY][s][p]   = (p == 0) && !busy && cpu_valid
                                          && (cpu_seg == SEG_W'(s));
                bk_wd[CPU_COPY][s][p]   = cpu_data;
                bk_addr[RENDER_COPY][s][p] = busy ? {wr_k, 1'(p)}
                                           : ((p == 0) ? rd_off : '0);
                bk_we[RENDER_COPY][s][p]   = busy && wr_v;
                bk_wd[RENDER_COPY][s][p]   = bk_rd[CPU_COPY][s][p];
            end
        end
    end

    for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
        for (genvar s = 0; s < NSEG; s++) begin : g_seg
            vram_bank #(.DW(DW), .AW(SEG_AW)) u_bank (
                .clk  (clk),
                .we   (bk_we[c][s]),
                .addr (bk_addr[c][s]),
                .wdata(bk_wd[c][s]),
                .rdata(bk_rd[c][s])
            );
        end
    end

    assign rd_data   = bk_rd[RENDER_COPY][rd_seg_q][0];
    assign cpu_ready = !busy;
    assign sync_busy = busy;

    // R9: a copy never restarts while it is still running
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sync_done) |=> (busy || sync_done));
endmodule

// File: tb/tb_vram_mirror_sync.sv
module tb_vram_mirror_sync;
    localparam int DW = 8, NSEG = 4, SEG_AW = 4, AW = 6, WORDS = 64;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          blank_start = 0, display_start = 0, cpu_valid = 0, rd_en = 0;
    logic [AW-1:0] cpu_addr = '0, rd_addr = '0;
    logic [DW-1:0] cpu_data = '0;
    logic          cpu_ready, rd_valid, sync_busy, sync_done, frame_dropped;
    logic [DW-1:0] rd_data;

    int checks = 0, errors = 0, cyc = 0;
    logic [DW-1:0] cpu_img [WORDS];
    logic [DW-1:0] shown   [WORDS];

    always #2.5 clk = ~clk;

    vram_mirror_sync #(.DW(DW), .NSEG(NSEG), .SEG_AW(SEG_AW)) dut (
        .clk(clk), .rst_n(rst_n), .blank_start(blank_start),
        .display_start(display_start), .cpu_valid(cpu_valid),
        .cpu_ready(cpu_ready), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .sync_busy(sync_busy), .sync_done(sync_done),
        .frame_dropped(frame_dropped)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cpu_valid = 1; cpu_addr = a; cpu_data = d;
        while (!cpu_ready) @(negedge clk);
        @(negedge clk);
        cpu_valid = 0;
        cpu_img[a] = d;
    endtask

    task automatic run_sync();
        @(negedge clk);
        blank_start = 1;
        @(negedge clk);
        blank_start = 0;
        while (sync_busy) @(negedge clk);
        for (int i = 0; i < WORDS; i++) shown[i] = cpu_img[i];
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < WORDS; a++) begin
            @(negedge clk);
            rd_en = 1; rd_addr = AW'(a);
            @(negedge clk);
            rd_en = 0;
            chk(req, {rd_valid, rd_data}, {1'b1, shown[a]});
        end
    endtask

    initial begin
        int busy_cnt, done_at, done_cnt;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", sync_busy, 0);
        chk("R1 done", sync_done, 0);
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 dropped", frame_dropped, 0);
        chk("R1 ready", cpu_ready, 1);
        rst_n = 1;
        @(negedge clk);

        // first pattern, copy, full readback (R6, R2)
        for (int a = 0; a < WORDS; a++) cpu_write(AW'(a), DW'(a * 7 + 3));
        run_sync();
        chk("R5 done pulse", sync_done, 1);
        @(negedge clk);
        chk("R5 done single", sync_done, 0);
        read_all("R6 first copy");
        @(negedge clk);
        chk("R2 no read no valid", rd_valid, 0);

        // second pattern: render copy must hold the first (R3)
        for (int a = 0; a < WORDS; a++) cpu_write(AW'(a), DW'(a) ^ 8'hA5);
        read_all("R3 isolation");
        run_sync();
        read_all("R6 second copy");

        // sparse rewrite: untouched words persist (R6)
        for (int a = 0; a < WORDS; a += 5) cpu_write(AW'(a), DW'(8'hC0 + a));
        run_sync();
        read_all("R6 sparse copy");

        // R7: write accepted on the starting edge
        @(negedge clk);
        blank_start = 1; cpu_valid = 1; cpu_addr = 6'd10; cpu_data = 8'hEE;
        @(negedge clk);
        blank_start = 0; cpu_valid = 0;
        cpu_img[10] = 8'hEE;
        while (sync_busy) @(negedge clk);
        for (int i = 0; i < WORDS; i++) shown[i] = cpu_img[i];
        read_all("R7 edge write");

        // R4, R5, R8, R9: busy length, drop, ignored restart
        busy_cnt = 0; done_at = -1; done_cnt = 0;
        for (int a = 0; a < WORDS; a++) cpu_img[a] = DW'(a * 3 + 1);
        for (int a = 0; a < WORDS; a++) cpu_write(AW'(a), cpu_img[a]);
        @(negedge clk);
        blank_start = 1;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (sync_busy) busy_cnt++;
            if (sync_done) begin done_cnt++; done_at = c; end
            if (c == 1) chk("R4 ready low", cpu_ready, 0);
            if (c == 3) chk("R8 drop set", frame_dropped, 1);
            if (c == 5) chk("R4 read refused", rd_valid, 0);
            blank_start   = (c == 3);
            display_start = (c == 2);
            rd_en         = (c == 4);
        end
        blank_start = 0; display_start = 0; rd_en = 0;
        chk("R4 R9 busy length", busy_cnt, 9);
        chk("R5 done position", done_at, 9);
        chk("R5 done count", done_cnt, 1);
        chk("R8 drop holds", frame_dropped, 1);
        for (int i = 0; i < WORDS; i++) shown[i] = cpu_img[i];
        read_all("R9 copy intact");
        @(negedge clk);
        display_start = 1;
        @(negedge clk);
        display_start = 0;
        chk("R8 drop cleared", frame_dropped, 0);

        // R10: write held through a stall
        @(negedge clk);
        blank_start = 1;
        @(negedge clk);
        blank_start = 0;
        cpu_valid = 1; cpu_addr = 6'd33; cpu_data = 8'h5A;
        chk("R10 stalled", cpu_ready, 0);
        while (!cpu_ready) @(negedge clk);
        @(negedge clk);
        cpu_valid = 0;
        cpu_img[33] = 8'h5A;
        run_sync();
        read_all("R10 held write");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule